// File: doc/BRIEF.md
# Double-Word Validating Pulse-Width Address/Data Decoder

This block receives a serial remote-control stream in which every digit is sent as two pulses of varying width. Each pulse is classified as short or long by looking at the line a fixed time after its rising edge. Pulse pairs are turned back into trinary digits (zero, one, open). Word and transmission boundaries are not marked by framing bits. They are found from how long the line stays low.

A word carries nine digits. The first five are compared with a local trinary address, given as a level/open pair per digit. The last four are taken as binary data, with a received open read as 1. A nibble is never trusted from one word alone. The first matching word only parks its nibble internally. The data outputs are loaded, and the valid flag goes high, only when the next consecutive word also matches the address and carries the same nibble. The flag falls on a rejected word, on a data change, or when the line goes quiet long enough to end the transmission. The data outputs keep their last validated value.

The decoder clock is a fixed multiple `CLK_PER_ENC` of the encoder clock. One data period (one digit) is 8 encoder clocks, so each pulse slot is 4 encoder clocks long. A short pulse is high for 1 encoder clock and a long pulse for 3.

Top module: `rxd_pair_decoder`

## Requirements
- R1: While reset is applied, and on the first cycle after it is released, `valid_o` is 0 and `data_o` is all zeros.
- R2: The line passes through a two-stage synchroniser. A pulse is long (1) when the synchronised line is still high `SAMPLE_CYC` = floor(1.72 × `CLK_PER_ENC`) cycles after its rising edge, and short (0) otherwise. Pulse pairs decode as follows: short,short is zero; long,long is one; long,short is open; short,long is a framing error that rejects the word.
- R3: Received digit k (k = 0..4, in arrival order) matches the local address as follows. If `addr_open_i[k]` = 1, only an open matches. Otherwise a one matches when `addr_lvl_i[k]` = 1, and a zero matches when `addr_lvl_i[k]` = 0. A word is address-matching only when all five digits match.
- R4: Received digit 5+j gives `data_o[j]`. A zero gives 0, and both one and open give 1. Nibbles are compared after this mapping.
- R5: A matching, well-formed word that has no stored first word before it only stores its nibble. `data_o` and `valid_o` do not change.
- R6: A matching word whose nibble equals the stored nibble loads `data_o` and sets `valid_o` on the cycle after the end of the word.
- R7: A matching word whose nibble differs from the stored nibble clears `valid_o` and leaves `data_o` unchanged. Its nibble becomes the stored nibble, so the next equal word validates.
- R8: A word that fails the address match, contains a framing error, or holds a nonzero digit count other than nine clears `valid_o` and discards the stored first word. An end of word with no digits received is ignored.
- R9: The line low for 2 data periods (`EOW_CYC` cycles) ends a word. The line low for 4 data periods (`EOT_CYC` cycles) ends the transmission, which clears `valid_o` and the stored first word.
- R10: `data_o` changes only when a pair is validated. It keeps its value after `valid_o` falls.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Decoder clock, `CLK_PER_ENC` times the encoder clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| line_i | input | 1 | Serial pulse-width data line |
| addr_lvl_i | input | ADDR_DIGITS | Local address level per digit (used when not open) |
| addr_open_i | input | ADDR_DIGITS | Local address digit expects an open |
| data_o | output | DATA_DIGITS | Validated data nibble |
| valid_o | output | 1 | Valid-transmission flag |

## Verification
Word pairs are sent with these variations, each chosen to separate one decision from its neighbours:
- Equal and unequal nibbles.
- Addresses that differ from the local one only in the open position, which separates open from one and from zero.
- Data digits sent as open, including an open paired against a one.
- A framing-error digit in the first word.

Directed sequences then cover the remaining cases:
- A lone first word.
- A continuous stream whose nibble changes partway through.
- A truncated word between two good ones.
- Silence long enough to end the transmission, which shows the data outputs hold their value after the flag drops.
- A reset taken while the flag is high.

// File: rtl/rxd_pkg.sv
package rxd_pkg;

  typedef enum logic [1:0] {
    DG_ZERO = 2'd0,
    DG_ONE  = 2'd1,
    DG_OPEN = 2'd2,
    DG_BAD  = 2'd3
  } digit_e;

  // first/second pulse widths (1 = long) to a digit
  function automatic digit_e pair_to_digit(input logic first_long, input logic second_long);
    case ({first_long, second_long})
      2'b00:   return DG_ZERO;
      2'b11:   return DG_ONE;
      2'b10:   return DG_OPEN;
      default: return DG_BAD;
    endcase
  endfunction

endpackage

// File: rtl/rxd_pulse_slicer.sv
module rxd_pulse_slicer #(
  parameter int SAMPLE_CYC = 13,
  parameter int EOW_CYC    = 128,
  parameter int EOT_CYC    = 256
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_i,
  output logic bit_vld_o,
  output logic bit_long_o,
  output logic eow_o,
  output logic eot_o
);

  localparam int CW = $clog2(EOT_CYC + 1);
  localparam logic [CW-1:0] SMP_LAST = CW'(SAMPLE_CYC - 1);
  localparam logic [CW-1:0] EOW_LAST = CW'(EOW_CYC - 1);
  localparam logic [CW-1:0] EOT_LAST = CW'(EOT_CYC - 1);
  localparam logic [CW-1:0] EOT_SAT  = CW'(EOT_CYC);

  logic [2:0]    sync_q;
  logic          arm_q, arm_d;
  logic [CW-1:0] hi_cnt_q, hi_cnt_d;
  logic [CW-1:0] lo_cnt_q, lo_cnt_d;
  logic          line_s, rise;

  assign line_s = sync_q[1];
  assign rise   = sync_q[1] & ~sync_q[2];

  always_comb begin
    arm_d     = arm_q;
    hi_cnt_d  = hi_cnt_q;
    bit_vld_o = 1'b0;
    if (rise) begin
      arm_d    = 1'b1;
      hi_cnt_d = '0;
    end else if (arm_q) begin
      if (hi_cnt_q == SMP_LAST) begin
        arm_d     = 1'b0;
        bit_vld_o = 1'b1;
      end else begin
        hi_cnt_d = hi_cnt_q + 1'b1;
      end
    end
  end

  assign bit_long_o = line_s;

  always_comb begin
    lo_cnt_d = lo_cnt_q;
    if (line_s) begin
      lo_cnt_d = '0;
    end else if (lo_cnt_q != EOT_SAT) begin
      lo_cnt_d = lo_cnt_q + 1'b1;
    end
  end

  assign eow_o = !line_s && (lo_cnt_q == EOW_LAST);
  assign eot_o = !line_s && (lo_cnt_q == EOT_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q   <= '0;
      arm_q    <= 1'b0;
      hi_cnt_q <= '0;
      lo_cnt_q <= '0;
    end else begin
      sync_q   <= {sync_q[1:0], line_i};
      arm_q    <= arm_d;
      hi_cnt_q <= hi_cnt_d;
      lo_cnt_q <= lo_cnt_d;
    end
  end

endmodule

// File: rtl/rxd_digit_collect.sv
module rxd_digit_collect
  import rxd_pkg::*;
#(
  parameter int NDIG = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_vld_i,
  input  logic              bit_long_i,
  input  logic              eow_i,
  output logic              word_vld_o,
  output logic              word_ok_o,
  output logic [2*NDIG-1:0] word_dig_o
);

  localparam int CNTW = $clog2(NDIG + 1);
  localparam logic [CNTW-1:0] CNT_FULL = CNTW'(NDIG);

  logic              half_q, half_d;
  logic              first_q, first_d;
  logic              err_q, err_d;
  logic [CNTW-1:0]   cnt_q, cnt_d;
  logic [2*NDIG-1:0] dig_q, dig_d;
  digit_e            dg;

  assign dg = pair_to_digit(first_q, bit_long_i);

  always_comb begin
    half_d     = half_q;
    first_d    = first_q;
    err_d      = err_q;
    cnt_d      = cnt_q;
    dig_d      = dig_q;
    word_vld_o = 1'b0;
    word_ok_o  = 1'b0;
    if (eow_i) begin
      word_vld_o = (cnt_q != '0) || half_q;
      word_ok_o  = (cnt_q == CNT_FULL) && !half_q && !err_q;
      half_d     = 1'b0;
      err_d      = 1'b0;
      cnt_d      = '0;
    end else if (bit_vld_i) begin
      if (!half_q) begin
        half_d  = 1'b1;
        first_d = bit_long_i;
      end else begin
        half_d = 1'b0;
        if (dg == DG_BAD) err_d = 1'b1;
        if (cnt_q == CNT_FULL) begin
          err_d = 1'b1;
        end else begin
          cnt_d = cnt_q + 1'b1;
          for (int i = 0; i < NDIG; i++) begin
            if (cnt_q == CNTW'(i)) dig_d[2*i +: 2] = dg;
          end
        end
      end
    end
  end

  assign word_dig_o = dig_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      half_q  <= 1'b0;
      first_q <= 1'b0;
      err_q   <= 1'b0;
      cnt_q   <= '0;
      dig_q   <= '0;
    end else begin
      half_q  <= half_d;
      first_q <= first_d;
      err_q   <= err_d;
      cnt_q   <= cnt_d;
      dig_q   <= dig_d;
    end
  end

endmodule

// File: rtl/rxd_word_judge.sv
module rxd_word_judge
  import rxd_pkg::*;
#(
  parameter int ADDR_DIGITS = 5,
  parameter int DATA_DIGITS = 4
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 word_vld_i,
  input  logic                                 word_ok_i,
  input  logic [2*(ADDR_DIGITS+DATA_DIGITS)-1:0] word_dig_i,
  input  logic                                 eot_i,
  input  logic [ADDR_DIGITS-1:0]               addr_lvl_i,
  input  logic [ADDR_DIGITS-1:0]               addr_open_i,
  output logic [DATA_DIGITS-1:0]               data_o,
  output logic                                 valid_o
);

  logic [ADDR_DIGITS-1:0] addr_hit;
  logic [DATA_DIGITS-1:0] nib;

  for (genvar k = 0; k < ADDR_DIGITS; k++) begin : g_addr
    logic [1:0] d;
    assign d = word_dig_i[2*k +: 2];
    assign addr_hit[k] = addr_open_i[k] ? (d == DG_OPEN)
                       : (d == (addr_lvl_i[k] ? DG_ONE : DG_ZERO));
  end

  for (genvar j = 0; j < DATA_DIGITS; j++) begin : g_data
    assign nib[j] = (word_dig_i[2*(ADDR_DIGITS+j) +: 2] != DG_ZERO);
  end

  logic                   have_q, have_d;
  logic [DATA_DIGITS-1:0] stash_q, stash_d;
  logic [DATA_DIGITS-1:0] data_q, data_d;
  logic                   valid_q, valid_d;
  logic                   good;

  assign good = word_ok_i && (&addr_hit);

  always_comb begin
    have_d  = have_q;
    stash_d = stash_q;
    data_d  = data_q;
    valid_d = valid_q;
    if (word_vld_i) begin
      if (!good) begin
        have_d  = 1'b0;
        valid_d = 1'b0;
      end else if (!have_q) begin
        have_d  = 1'b1;
        stash_d = nib;
      end else if (nib == stash_q) begin
        data_d  = nib;
        valid_d = 1'b1;
      end else begin
        valid_d = 1'b0;
        stash_d = nib;
      end
    end else if (eot_i) begin
      have_d  = 1'b0;
      valid_d = 1'b0;
    end
  end

  assign data_o  = data_q;
  assign valid_o = valid_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      have_q  <= 1'b0;
      stash_q <= '0;
      data_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      have_q  <= have_d;
      stash_q <= stash_d;
      data_q  <= data_d;
      valid_q <= valid_d;
    end
  end

endmodule

// File: rtl/rxd_pair_decoder.sv
module rxd_pair_decoder #(
  parameter int CLK_PER_ENC = 8,
  parameter int ADDR_DIGITS = 5,
  parameter int DATA_DIGITS = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   line_i,
  input  logic [ADDR_DIGITS-1:0] addr_lvl_i,
  input  logic [ADDR_DIGITS-1:0] addr_open_i,
  output logic [DATA_DIGITS-1:0] data_o,
  output logic                   valid_o
);

  localparam int NDIG       = ADDR_DIGITS + DATA_DIGITS;
  localparam int SAMPLE_CYC = (CLK_PER_ENC * 172) / 100;
  localparam int DATA_PER   = 8 * CLK_PER_ENC;
  localparam int EOW_CYC    = 2 * DATA_PER;
  localparam int EOT_CYC    = 4 * DATA_PER;

  logic [1:0] rst_sync_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sync_n = rst_sync_q[1];

  logic              bit_vld, bit_long, eow, eot;
  logic              word_vld, word_ok;
  logic [2*NDIG-1:0] word_dig;

  rxd_pulse_slicer #(
    .SAMPLE_CYC (SAMPLE_CYC),
    .EOW_CYC    (EOW_CYC),
    .EOT_CYC    (EOT_CYC)
  ) u_slicer (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .line_i     (line_i),
    .bit_vld_o  (bit_vld),
    .bit_long_o (bit_long),
    .eow_o      (eow),
    .eot_o      (eot)
  );

  rxd_digit_collect #(
    .NDIG (NDIG)
  ) u_collect (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .bit_vld_i  (bit_vld),
    .bit_long_i (bit_long),
    .eow_i      (eow),
    .word_vld_o (word_vld),
    .word_ok_o  (word_ok),
    .word_dig_o (word_dig)
  );

  rxd_word_judge #(
    .ADDR_DIGITS (ADDR_DIGITS),
    .DATA_DIGITS (DATA_DIGITS)
  ) u_judge (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .word_vld_i  (word_vld),
    .word_ok_i   (word_ok),
    .word_dig_i  (word_dig),
    .eot_i       (eot),
    .addr_lvl_i  (addr_lvl_i),
    .addr_open_i (addr_open_i),
    .data_o      (data_o),
    .valid_o     (valid_o)
  );

endmodule

// File: rtl/rxd_pair_decoder_chk.sv
module rxd_pair_decoder_chk #(
  parameter int DATA_DIGITS = 4
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   valid_o,
  input logic [DATA_DIGITS-1:0] data_o,
  input logic                   bit_vld,
  input logic                   eow,
  input logic                   eot,
  input logic                   word_vld,
  input logic                   word_ok
);

  AST_RST_OUT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!valid_o && data_o == '0));                         // R1

  AST_ONE_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({bit_vld, eow, eot}));                                        // R2

  AST_RISE_AFTER_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(valid_o) |-> $past(word_vld && word_ok));                        // R6

  AST_BAD_WORD_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (word_vld && !word_ok) |=> !valid_o);                                  // R8

  AST_EOT_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    eot |=> !valid_o);                                                     // R9

  AST_DATA_ONLY_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(data_o) |-> valid_o);                                         // R10

endmodule

bind rxd_pair_decoder rxd_pair_decoder_chk #(.DATA_DIGITS(DATA_DIGITS)) u_chk (
  .clk      (clk),
  .rst_n    (rst_sync_n),
  .valid_o  (valid_o),
  .data_o   (data_o),
  .bit_vld  (bit_vld),
  .eow      (eow),
  .eot      (eot),
  .word_vld (word_vld),
  .word_ok  (word_ok)
);

// File: tb/rxd_pair_decoder_tb.sv
module rxd_pair_decoder_tb;

  localparam int CPE  = 8;
  localparam int SLOT = 4 * CPE;   // one pulse slot
  localparam int PER  = 2 * SLOT;  // one data period (digit)

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       line = 1'b0;
  logic [4:0] addr_lvl  = 5'b01001;  // digits: 1,0,-,1,0
  logic [4:0] addr_open = 5'b00100;  // digit 2 expects open
  logic [3:0] data_o;
  logic       valid_o;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #10 clk = ~clk;

  rxd_pair_decoder #(.CLK_PER_ENC(CPE)) u_dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .line_i      (line),
    .addr_lvl_i  (addr_lvl),
    .addr_open_i (addr_open),
    .data_o      (data_o),
    .valid_o     (valid_o)
  );

  // address digit codes 0=zero 1=one 2=open 3=short-long
  localparam logic [9:0] A_OK = 10'h061;

  // {exp_valid, addr, data word1, data word2}
  localparam logic [26:0] VEC [9] = '{
    {1'b1, 10'h061, 8'h44, 8'h44},  // R6 nibble 1010
    {1'b1, 10'h061, 8'h11, 8'h11},  // R6 nibble 0101
    {1'b1, 10'h061, 8'h08, 8'h08},  // R4 open data digit -> 0010
    {1'b0, 10'h061, 8'h44, 8'h11},  // R7 nibbles differ
    {1'b0, 10'h051, 8'h55, 8'h55},  // R3 one where open expected
    {1'b0, 10'h041, 8'h55, 8'h55},  // R3 zero where open expected
    {1'b1, 10'h061, 8'hAA, 8'h55},  // R4 open equals one after mapping
    {1'b0, 10'h061, 8'h0C, 8'h00},  // R2 framing error in word 1
    {1'b1, 10'h061, 8'h00, 8'h00}   // R6 nibble 0000
  };

  function automatic logic [3:0] nib_of(input logic [7:0] d);
    logic [3:0] n;
    for (int j = 0; j < 4; j++) n[j] = (d[2*j +: 2] != 2'd0);
    return n;
  endfunction

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_slot(input bit lng);
    line = 1'b1;
    wait_cyc(lng ? 3 * CPE : CPE);
    line = 1'b0;
    wait_cyc(lng ? CPE : 3 * CPE);
  endtask

  task automatic send_digit(input logic [1:0] c);
    case (c)
      2'd0: begin send_slot(0); send_slot(0); end
      2'd1: begin send_slot(1); send_slot(1); end
      2'd2: begin send_slot(1); send_slot(0); end
      default: begin send_slot(0); send_slot(1); end
    endcase
  endtask

  // word, then 3 data periods of silence (end of word, not end of transmission)
  task automatic send_word(input logic [9:0] a, input logic [7:0] d, input int ndig);
    logic [17:0] w;
    w = {d, a};
    for (int k = 0; k < ndig; k++) send_digit(w[2*k +: 2]);
    wait_cyc(3 * PER);
  endtask

  task automatic check(input string req, input logic [4:0] exp);
    total++;
    if ({valid_o, data_o} !== exp) begin
      bad++;
      $display("FAIL %s: valid/data act=%b/%b exp=%b/%b", req,
               valid_o, data_o, exp[4], exp[3:0]);
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: act=running exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : main
    logic [3:0] held;
    wait_cyc(3);
    check("R1 in reset", 5'b0_0000);
    @(negedge clk) rst_n = 1'b1;
    wait_cyc(1);
    check("R1 after release", 5'b0_0000);
    wait_cyc(5 * PER);  // startup idle passes end of transmission
    held = 4'b0000;

    for (int i = 0; i < 9; i++) begin
      logic [26:0] v;
      string tag;
      v = VEC[i];
      case (i)
        2, 6:    tag = "R4";
        3:       tag = "R7";
        4, 5:    tag = "R3";
        7:       tag = "R2";
        default: tag = "R6";
      endcase
      send_word(v[25:16], v[15:8], 9);
      send_word(v[25:16], v[7:0], 9);
      if (v[26]) held = nib_of(v[7:0]);
      check($sformatf("%s vector %0d", tag, i), {v[26], held});
      wait_cyc(2 * PER);  // now past end of transmission
      check($sformatf("R9 vector %0d idle", i), {1'b0, held});
    end

    // R5: lone first word leaves outputs alone
    send_word(A_OK, 8'h44, 9);
    check("R5 first word only", {1'b0, held});
    wait_cyc(2 * PER);

    // R7 continuous stream with nibble change
    send_word(A_OK, 8'h44, 9);
    send_word(A_OK, 8'h44, 9);
    check("R6 stream pair A", 5'b1_1010);
    send_word(A_OK, 8'h11, 9);
    check("R7 stream change", 5'b0_1010);
    send_word(A_OK, 8'h11, 9);
    check("R7 stream pair B", 5'b1_0101);
    send_word(10'h041, 8'h11, 9);
    check("R8 address miss drops", 5'b0_0101);
    send_word(A_OK, 8'h11, 9);
    check("R8 stored word cleared", 5'b0_0101);
    wait_cyc(2 * PER);

    // R8 truncated word between two good ones
    send_word(A_OK, 8'h55, 9);
    send_word(A_OK, 8'h55, 8);
    send_word(A_OK, 8'h55, 9);
    check("R8 short word clears", 5'b0_0101);
    send_word(A_OK, 8'h55, 9);
    check("R8 recovers", 5'b1_1111);
    wait_cyc(2 * PER);
    check("R10 data held after drop", 5'b0_1111);

    // R1 reset while valid
    send_word(A_OK, 8'h44, 9);
    send_word(A_OK, 8'h44, 9);
    check("R6 before reset", 5'b1_1010);
    rst_n = 1'b0;
    wait_cyc(2);
    check("R1 reset while valid", 5'b0_0000);
    rst_n = 1'b1;
    wait_cyc(4);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule